// File: doc/BRIEF.md
# Shake-Triggered Message Player

This block sequences playback of a fixed audio message held in an external read-only memory of 4096 sixteen-bit words. It sits idle until a shake sensor input is seen high, then walks the memory from the first word to the last. For every word it first presents the address with the memory enable raised. In the following cycle it pulses a load strobe, so that the converter captures the word the memory now drives on its data bus. The memory has address and enable inputs only, because nothing is ever written.

Each word takes two cycles, so a full message lasts 2 × DEPTH cycles. After the strobe for the last word the controller returns to idle with its address cleared. A shake seen while a message is playing does not alter it. A new message starts only when the shake input is high in a cycle where the controller is idle. Sensor debouncing, the memory itself and the analog stage lie outside the block.

Top module: `chime_player`

## Requirements
- R1: A synchronous active-high `rst` forces `rom_en`=0, `dac_load`=0 and `rom_addr`=0 in the cycle after the edge that samples it, even while `shake` is high.
- R2: While idle (`rom_en`=0 and `dac_load`=0) with `shake` low, the outputs stay `rom_en`=0, `dac_load`=0, `rom_addr`=0 in the next cycle.
- R3: An edge that samples `shake`=1 while idle is followed by a cycle with `rom_en`=1 and `rom_addr`=0.
- R4: Every cycle with `rom_en`=1 is followed by a cycle with `rom_en`=0, `dac_load`=1 and the same `rom_addr`. `rom_en` and `dac_load` are never 1 together. In the load cycle the memory's registered output holds the word at that address.
- R5: After the load cycle for address k < DEPTH-1, the next cycle has `rom_en`=1 and `rom_addr`=k+1. Every word 0..DEPTH-1 is fetched exactly once, in ascending order.
- R6: After the load cycle for address DEPTH-1, the next cycle is idle with `rom_addr`=0, so a message lasts exactly 2×DEPTH cycles.
- R7: `shake` has no effect during playback. After a message ends, a restart needs `shake` high in an idle cycle. If `shake` is held high throughout, exactly one idle cycle separates two messages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shake | input | 1 | Level trigger from the shake sensor |
| rom_addr | output | $clog2(DEPTH) | Word address to the message memory |
| rom_en | output | 1 | Read enable to the message memory |
| dac_load | output | 1 | Load strobe to the converter |

## Verification
A wrong state register or address counter becomes visible at the ports within one or two cycles. Examples are a missed or doubled strobe, an address that skips or repeats, an early or late return to idle, or a restart caused by a shake during playback. The bench checks every cycle of each message against the arithmetic pattern: the enable on even offsets, the load on odd offsets, and the address equal to half the offset. It also checks the word captured at each load against a computed memory image. Any such fault is therefore reported in the cycle where it appears.

// File: rtl/chime_pkg.sv
package chime_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_FETCH  = 2'd1,
    PS_STROBE = 2'd2
  } play_st_t;
endpackage

// File: rtl/chime_addr_ctr.sv
module chime_addr_ctr #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      addr <= '0;
    end else if (step) begin
      addr <= addr + AW'(1);
    end
  end

  assign at_end = (addr == LAST);
endmodule

// File: rtl/chime_seq_fsm.sv
module chime_seq_fsm
  import chime_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     trig,
  input  logic     at_end,
  output play_st_t nxt_st,
  output logic     clr,
  output logic     step
);
  play_st_t cur_st;

  always_comb begin
    nxt_st = cur_st;
    case (cur_st)
      PS_IDLE:   nxt_st = trig ? PS_FETCH : PS_IDLE;
      PS_FETCH:  nxt_st = PS_STROBE;
      PS_STROBE: nxt_st = at_end ? PS_IDLE : PS_FETCH;
      default:   nxt_st = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_st <= PS_IDLE;
    end else begin
      cur_st <= nxt_st;
    end
  end

  assign clr  = (nxt_st == PS_IDLE);
  assign step = (cur_st == PS_STROBE) && (nxt_st == PS_FETCH);
endmodule

// File: rtl/chime_out_reg.sv
module chime_out_reg
  import chime_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  play_st_t nxt_st,
  output logic     rd_en,
  output logic     ld_stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en  <= 1'b0;
      ld_stb <= 1'b0;
    end else begin
      rd_en  <= (nxt_st == PS_FETCH);
      ld_stb <= (nxt_st == PS_STROBE);
    end
  end
endmodule

// File: rtl/chime_player.sv
module chime_player
  import chime_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shake,
  output logic [AW-1:0] rom_addr,
  output logic          rom_en,
  output logic          dac_load
);
  play_st_t nxt_st;
  logic     ctr_clr;
  logic     ctr_step;
  logic     ctr_end;

  chime_seq_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .trig   (shake),
    .at_end (ctr_end),
    .nxt_st (nxt_st),
    .clr    (ctr_clr),
    .step   (ctr_step)
  );

  chime_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .clr    (ctr_clr),
    .step   (ctr_step),
    .addr   (rom_addr),
    .at_end (ctr_end)
  );

  chime_out_reg u_out (
    .clk    (clk),
    .rst    (rst),
    .nxt_st (nxt_st),
    .rd_en  (rom_en),
    .ld_stb (dac_load)
  );
endmodule

// File: rtl/chime_player_chk.sv
module chime_player_chk #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          shake,
  input logic [AW-1:0] rom_addr,
  input logic          rom_en,
  input logic          dac_load
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!rom_en && !dac_load && rom_addr == '0));

  a_r2_stay_idle: assert property (@(posedge clk) disable iff (rst)
    (!rom_en && !dac_load && !shake) |=> (!rom_en && !dac_load && rom_addr == '0));

  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    (!rom_en && !dac_load && shake) |=> (rom_en && rom_addr == '0));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rom_en && dac_load));

  a_r4_load_follows: assert property (@(posedge clk) disable iff (rst)
    rom_en |=> (dac_load && !rom_en && $stable(rom_addr)));

  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    (dac_load && rom_addr != LAST) |=> (rom_en && rom_addr == $past(rom_addr) + AW'(1)));

  a_r6_finish: assert property (@(posedge clk) disable iff (rst)
    (dac_load && rom_addr == LAST) |=> (!rom_en && !dac_load && rom_addr == '0));
endmodule

bind chime_player chime_player_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_chime_player.sv
`timescale 1ns/1ps
module sim_chime_player;
  localparam int DEPTH = 4096;
  localparam int AW    = $clog2(DEPTH);
  localparam int WDOG  = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          shake = 1'b0;
  logic [AW-1:0] rom_addr;
  logic          rom_en;
  logic          dac_load;
  logic [15:0]   rom_q = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  chime_player #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .shake(shake),
    .rom_addr(rom_addr), .rom_en(rom_en), .dac_load(dac_load)
  );

  function automatic logic [15:0] img(input int a);
    return 16'((a * 40503) ^ 23130);
  endfunction

  // message memory model: registered read, one cycle latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rom_en) rom_q <= img(int'(rom_addr));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(!rom_en,   req, int'(rom_en), 0);
    chk(!dac_load, req, int'(dac_load), 0);
    chk(rom_addr == '0, req, int'(rom_addr), 0);
  endtask

  // Plays from an idle controller; checks ncyc cycles of the message.
  task automatic play(input bit hold, input bit noise, input int ncyc);
    @(negedge clk) shake = 1'b1;
    for (int t = 0; t < ncyc; t++) begin
      @(posedge clk); #1;
      if (t == 0) chk(rom_en && rom_addr == '0, "R3", int'(rom_en), 1);
      chk(rom_en == (t % 2 == 0), "R4", int'(rom_en), int'(t % 2 == 0));
      chk(dac_load == (t % 2 == 1), "R4", int'(dac_load), int'(t % 2 == 1));
      chk(int'(rom_addr) == t / 2, "R5", int'(rom_addr), t / 2);
      if (t % 2 == 1) chk(rom_q == img(t / 2), "R4", int'(rom_q), int'(img(t / 2)));
      @(negedge clk);
      if (hold)                 shake = 1'b1;
      else if (t == 2*DEPTH-1)  shake = 1'b0;
      else if (noise)           shake = (t % 7 == 3) || (t % 1000 > 990); // R7 noise
      else                      shake = 1'b0;
    end
    if (ncyc == 2*DEPTH) begin
      @(posedge clk); #1;
      chk_idle("R6");
    end
  endtask

  initial begin
    // R1: reset holds the block idle even with shake high
    shake = 1'b1;
    repeat (4) begin
      @(posedge clk); #1;
      chk_idle("R1");
    end
    @(negedge clk) begin rst = 1'b0; shake = 1'b0; end
    // R2: idle with shake low
    repeat (20) begin
      @(posedge clk); #1;
      chk_idle("R2");
    end
    // one-cycle trigger, clean message
    play(1'b0, 1'b0, 2*DEPTH);
    // R7: no restart without a new trigger
    repeat (10) begin
      @(posedge clk); #1;
      chk_idle("R7");
    end
    // R7: shake pulses during playback are ignored
    play(1'b0, 1'b1, 2*DEPTH);
    repeat (5) begin
      @(posedge clk); #1;
      chk_idle("R7");
    end
    // R7: shake held high, messages back to back after one idle cycle
    play(1'b1, 1'b0, 2*DEPTH);
    play(1'b0, 1'b0, 2*DEPTH);
    repeat (3) begin
      @(posedge clk); #1;
      chk_idle("R7");
    end
    // R1: reset in the middle of a message
    play(1'b0, 1'b0, 301);
    @(negedge clk) begin rst = 1'b1; shake = 1'b1; end
    @(posedge clk); #1;
    chk_idle("R1");
    @(negedge clk) begin rst = 1'b0; shake = 1'b0; end
    repeat (4) begin
      @(posedge clk); #1;
      chk_idle("R2");
    end
    // full message again after the reset
    play(1'b0, 1'b0, 2*DEPTH);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= WDOG);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, WDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule